// File: doc/BRIEF.md
# PWM Clock-Enable Source Generator

This block produces the counting enables for a small multi-channel PWM unit. Everything runs on one master clock. A free-running prescaler counter yields eleven power-of-two enable taps: tap k pulses once every 2^k master cycles. Two programmable rate generators, A and B, each pick one tap through a small mux and then divide the tap's pulse rate by an 8-bit linear value. The output rate of each generator is the master rate / (2^mux × divide).

Each PWM channel holds a 4-bit source code that selects one of thirteen enables:
- Codes 0 to 10 select the prescaler taps.
- Code 11 selects generator A.
- Code 12 selects generator B.

Every output is a one-cycle enable pulse in the master clock domain. None of them is a derived clock, so the channel counters can run from the same clock and advance on these pulses.

Software sees one 32-bit divider configuration word, which can be written one half at a time. It also sees a per-channel source code write port with a channel mask.

Top module: `pwmclk_gen`

## Requirements
- R1: Counting e as the number of rising edges with `rst` low since reset, a channel holding code k in 0..10 shows `ch_tick` high after edge e exactly when e ≥ 2 and (e − 1) is a multiple of 2^k. Code 0 is therefore high on every cycle from e = 2 on.
- R2: A channel holding code 11 (or 12) shows, one cycle later, the pulse train of `div_tick[0]` (or `div_tick[1]`).
- R3: A source write with a code of 13, 14 or 15 is ignored, and the channel keeps its previous code. Stored codes never exceed 12.
- R4: For a generator with divide value D ≥ 1 and mux value M ≤ 10, `div_tick` pulses once per D pulses of tap M, that is, once every 2^M × D master cycles. Writing that generator's half of the word restarts its linear count from zero.
- R5: Generator A uses bits 15:0 of the configuration word and generator B uses bits 31:16. Within each half, bits 7:0 are the divide value and bits 11:8 are the mux value. Bits 15:12 and 31:28 are always read back as zero, whatever was written.
- R6: `cfg_we[0]` writes only the low half and `cfg_we[1]` writes only the high half. The half that is not enabled keeps its value.
- R7: A divide value of 0 keeps that generator's `div_tick` low.
- R8: A mux value of 11 to 15 selects no tap and keeps that generator's `div_tick` low.
- R9: While `rst` is high at a rising edge, the configuration word, all source codes and all tick outputs become zero, and the prescaler count restarts from zero.
- R10: One source write updates every channel whose bit is set in `src_wr`, all with the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 2 | Half-word write enables: bit 0 for generator A, bit 1 for generator B |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration word read back |
| src_wr | input | NCH | Channel mask for a source code write |
| src_wdata | input | 4 | Source code to write |
| src_sel | output | 4*NCH | Stored source codes, channel i in bits 4i+3:4i |
| div_tick | output | 2 | Enable pulses of generators A (bit 0) and B (bit 1) |
| ch_tick | output | NCH | Per-channel selected enable pulse |

## Verification
A bad prescaler count or tap decode shows up at once on `ch_tick`. It appears within 2^k cycles for a channel on code k, and a channel on code 0 or 1 exposes it in one or two cycles. A corrupted linear count in a generator is slower to surface: it moves the phase of `div_tick`, which becomes visible only at the next expected pulse, up to 2^M × D cycles later. A code or configuration half that is written when it should not be is visible on the next cycle at `src_sel` or `cfg_rdata`. The bench compares every output against an integer reference model on every cycle. It also counts pulses over fixed windows to confirm the rates.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;

  localparam int FIELD_W = 16;
  localparam int DIV_W   = 8;
  localparam int MUX_W   = 4;
  localparam int SRC_W   = 4;
  localparam int RSVD_W  = FIELD_W - DIV_W - MUX_W;

  localparam logic [SRC_W-1:0]   SRC_GEN_A  = 4'd11;
  localparam logic [SRC_W-1:0]   SRC_GEN_B  = 4'd12;
  localparam logic [FIELD_W-1:0] FIELD_KEEP = 16'h0FFF;

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic [MUX_W-1:0]  mux;
    logic [DIV_W-1:0]  div;
  } genfield_t;

  function automatic logic src_code_ok(input logic [SRC_W-1:0] code);
    return code <= SRC_GEN_B;
  endfunction

endpackage

// File: rtl/pwmclk_prescale.sv
module pwmclk_prescale #(
  parameter int NTAP = 11
) (
  input  logic            clk,
  input  logic            rst,
  output logic [NTAP-1:0] tap_q
);
  localparam int CW = (NTAP > 1) ? NTAP - 1 : 1;

  logic [CW-1:0]   cnt;
  logic [NTAP-1:0] tap_d;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    if (k == 0) begin : g_base
      assign tap_d[k] = 1'b1;
    end else begin : g_and
      assign tap_d[k] = &cnt[k-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tap_q <= '0;
    else     tap_q <= tap_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == $past(cnt) + 1'b1); // R9

  for (genvar k = 1; k < NTAP; k++) begin : g_nest
    AST_TAP_NESTED: assert property (@(posedge clk) disable iff (rst)
      tap_q[k] |-> tap_q[k-1]); // R1
  end

endmodule

// File: rtl/pwmclk_lindiv.sv
module pwmclk_lindiv #(
  parameter int NTAP  = 11,
  parameter int DIV_W = 8,
  parameter int MUX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTAP-1:0]  tap,
  input  logic [MUX_W-1:0] mux,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick_q
);
  logic             tap_sel;
  logic [DIV_W-1:0] dcnt;
  logic             at_end;
  logic             wrap;

  always_comb begin
    tap_sel = 1'b0;
    for (int k = 0; k < NTAP; k++) begin
      if (mux == MUX_W'(k)) tap_sel = tap[k];
    end
  end

  assign at_end = (div != '0) && (dcnt == div - 1'b1);
  assign wrap   = (div == '0) || (dcnt >= div - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || restart)  dcnt <= '0;
    else if (tap_sel)    dcnt <= wrap ? '0 : dcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= tap_sel && at_end;
  end

  AST_DIV_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !tick_q); // R7
  AST_MUX_RANGE: assert property (@(posedge clk) disable iff (rst)
    (mux >= MUX_W'(NTAP)) |=> !tick_q); // R8
  AST_TICK_NEEDS_TAP: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> $past(tap_sel)); // R4

endmodule

// File: rtl/pwmclk_chsel.sv
module pwmclk_chsel
  import pwmclk_pkg::*;
#(
  parameter int NTAP = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTAP-1:0]  tap,
  input  logic [1:0]       gen_tick,
  input  logic             wr,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] code_q,
  output logic             tick_q
);
  logic sel;

  always_ff @(posedge clk) begin
    if (rst)                          code_q <= '0;
    else if (wr && src_code_ok(wdata)) code_q <= wdata;
  end

  always_comb begin
    sel = 1'b0;
    for (int k = 0; k < NTAP; k++) begin
      if (code_q == SRC_W'(k)) sel = tap[k];
    end
    if (code_q == SRC_GEN_A) sel = gen_tick[0];
    if (code_q == SRC_GEN_B) sel = gen_tick[1];
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= sel;
  end

  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    code_q <= SRC_GEN_B); // R3
  AST_BAD_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (wr && !src_code_ok(wdata)) |=> $stable(code_q)); // R3
  AST_FOLLOW_GEN_A: assert property (@(posedge clk) disable iff (rst)
    (code_q == SRC_GEN_A) |=> (tick_q == $past(gen_tick[0]))); // R2

endmodule

// File: rtl/pwmclk_gen.sv
module pwmclk_gen
  import pwmclk_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NTAP = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_we,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic [NCH-1:0]     src_wr,
  input  logic [SRC_W-1:0]   src_wdata,
  output logic [NCH*SRC_W-1:0] src_sel,
  output logic [1:0]         div_tick,
  output logic [NCH-1:0]     ch_tick
);
  localparam int NGEN = 2;

  logic [NTAP-1:0] tap;

  pwmclk_prescale #(.NTAP(NTAP)) u_prescale (
    .clk   (clk),
    .rst   (rst),
    .tap_q (tap)
  );

  for (genvar d = 0; d < NGEN; d++) begin : g_gen
    genfield_t field_q;

    always_ff @(posedge clk) begin
      if (rst)            field_q <= '0;
      else if (cfg_we[d]) field_q <= cfg_wdata[d*FIELD_W +: FIELD_W] & FIELD_KEEP;
    end

    assign cfg_rdata[d*FIELD_W +: FIELD_W] = field_q;

    pwmclk_lindiv #(.NTAP(NTAP), .DIV_W(DIV_W), .MUX_W(MUX_W)) u_div (
      .clk     (clk),
      .rst     (rst),
      .tap     (tap),
      .mux     (field_q.mux),
      .div     (field_q.div),
      .restart (cfg_we[d]),
      .tick_q  (div_tick[d])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwmclk_chsel #(.NTAP(NTAP)) u_sel (
      .clk      (clk),
      .rst      (rst),
      .tap      (tap),
      .gen_tick (div_tick),
      .wr       (src_wr[i]),
      .wdata    (src_wdata),
      .code_q   (src_sel[i*SRC_W +: SRC_W]),
      .tick_q   (ch_tick[i])
    );
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[15:12] == 4'd0) && (cfg_rdata[31:28] == 4'd0)); // R5
  AST_HALF_B_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cfg_we == 2'b01) |=> (cfg_rdata[31:16] == $past(cfg_rdata[31:16]))); // R6
  AST_HALF_A_KEPT: assert property (@(posedge clk) disable iff (rst)
    (cfg_we == 2'b10) |=> (cfg_rdata[15:0] == $past(cfg_rdata[15:0]))); // R6

endmodule

// File: tb/test_pwmclk_gen.sv
module test_pwmclk_gen;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     cfg_we = '0;
  logic [31:0]    cfg_wdata = '0;
  logic [31:0]    cfg_rdata;
  logic [NCH-1:0] src_wr = '0;
  logic [3:0]     src_wdata = '0;
  logic [NCH*4-1:0] src_sel;
  logic [1:0]     div_tick;
  logic [NCH-1:0] ch_tick;

  always #5 clk = ~clk;

  pwmclk_gen #(.NCH(NCH), .NTAP(11)) i_pwmclk_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .src_wr(src_wr), .src_wdata(src_wdata), .src_sel(src_sel),
    .div_tick(div_tick), .ch_tick(ch_tick)
  );

  int    checks = 0, errors = 0;
  bit    done = 0;
  string tag = "R9";
  int    n_div[2];
  int    n_ch[NCH];

  // reference model state
  int m_cnt;
  bit m_tap[11];
  int m_dcnt[2];
  bit m_dtick[2];
  bit m_ch[NCH];
  int m_cfg[2];
  int m_src[NCH];

  always @(posedge clk) begin
    bit nt[11];
    bit nd[2];
    bit nc[NCH];
    int dv, mx;
    bit sel;
    if (rst) begin
      m_cnt = 0;
      for (int k = 0; k < 11; k++) m_tap[k] = 0;
      for (int d = 0; d < 2; d++) begin m_dcnt[d] = 0; m_dtick[d] = 0; m_cfg[d] = 0; end
      for (int i = 0; i < NCH; i++) begin m_ch[i] = 0; m_src[i] = 0; end
    end else begin
      for (int k = 0; k < 11; k++) nt[k] = ((m_cnt % (1 << k)) == (1 << k) - 1);
      for (int d = 0; d < 2; d++) begin
        dv  = m_cfg[d] & 255;
        mx  = (m_cfg[d] >> 8) & 15;
        sel = (mx <= 10) ? m_tap[mx] : 1'b0;
        nd[d] = sel && dv != 0 && m_dcnt[d] == dv - 1;
        if (cfg_we[d]) m_dcnt[d] = 0;
        else if (sel)  m_dcnt[d] = (dv == 0 || m_dcnt[d] >= dv - 1) ? 0 : m_dcnt[d] + 1;
      end
      for (int i = 0; i < NCH; i++)
        nc[i] = (m_src[i] <= 10) ? m_tap[m_src[i]] :
                (m_src[i] == 11) ? m_dtick[0] :
                (m_src[i] == 12) ? m_dtick[1] : 1'b0;
      for (int d = 0; d < 2; d++)
        if (cfg_we[d]) m_cfg[d] = int'((cfg_wdata >> (16 * d)) & 32'h0000_0FFF);
      for (int i = 0; i < NCH; i++)
        if (src_wr[i] && src_wdata <= 4'd12) m_src[i] = int'(src_wdata);
      m_cnt = (m_cnt + 1) % 1024;
      m_tap = nt; m_dtick = nd; m_ch = nc;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0]      e_rd;
    logic [NCH*4-1:0] e_src;
    logic [NCH-1:0]   e_ch;
    if (!done) begin
      e_rd = {m_cfg[1][15:0], m_cfg[0][15:0]};
      for (int i = 0; i < NCH; i++) begin
        e_src[i*4 +: 4] = m_src[i][3:0];
        e_ch[i] = m_ch[i];
      end
      chk(cfg_rdata === e_rd, "R5 R6 cfg_rdata", cfg_rdata, e_rd);
      chk(src_sel === e_src, "R3 R10 src_sel", 32'(src_sel), 32'(e_src));
      chk(div_tick === {m_dtick[1], m_dtick[0]}, "R4 div_tick", 32'(div_tick), 32'({m_dtick[1], m_dtick[0]}));
      chk(ch_tick === e_ch, "R1 R2 ch_tick", 32'(ch_tick), 32'(e_ch));
      for (int d = 0; d < 2; d++) if (div_tick[d] === 1'b1) n_div[d]++;
      for (int i = 0; i < NCH; i++) if (ch_tick[i] === 1'b1) n_ch[i]++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_counts();
    for (int d = 0; d < 2; d++) n_div[d] = 0;
    for (int i = 0; i < NCH; i++) n_ch[i] = 0;
  endtask

  task automatic wr_cfg(input logic [1:0] we, input logic [31:0] d);
    cfg_we = we; cfg_wdata = d;
    step(1);
    cfg_we = '0;
  endtask

  task automatic wr_src(input logic [NCH-1:0] m, input logic [3:0] c);
    src_wr = m; src_wdata = c;
    step(1);
    src_wr = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    tag = "R9";
    step(3);
    chk(cfg_rdata === 32'h0 && src_sel === '0, "R9 reset config", cfg_rdata, 32'h0);
    chk(ch_tick === '0 && div_tick === '0, "R9 reset ticks", 32'({div_tick, ch_tick}), 32'h0);
    rst = 1'b0;

    tag = "R1";
    wr_src(4'b0010, 4'd1);
    wr_src(4'b0100, 4'd4);
    wr_src(4'b1000, 4'd10);
    step(2100);
    clear_counts();
    step(160);
    chk(n_ch[2] == 10, "R1 code 4 pulses in 160", n_ch[2], 10);
    chk(n_ch[1] == 80, "R1 code 1 pulses in 160", n_ch[1], 80);
    chk(n_ch[0] == 160, "R1 code 0 every cycle", n_ch[0], 160);

    tag = "R4";
    wr_cfg(2'b11, 32'h0005_0203);
    tag = "R10";
    wr_src(4'b1100, 4'd12);
    chk(src_sel[15:8] === 8'hCC, "R10 masked write", 32'(src_sel), 32'h0000_CC10);
    tag = "R2";
    wr_src(4'b0001, 4'd11);
    step(50);
    clear_counts();
    step(120);
    chk(n_div[0] == 10, "R4 gen A period 12", n_div[0], 10);
    chk(n_div[1] == 24, "R4 gen B period 5", n_div[1], 24);
    chk(n_ch[0] == n_div[0], "R2 code 11 follows gen A", n_ch[0], n_div[0]);
    chk(n_ch[3] == n_div[1], "R2 code 12 follows gen B", n_ch[3], n_div[1]);

    tag = "R6";
    wr_cfg(2'b01, 32'hFFFF_0104);
    chk(cfg_rdata === 32'h0005_0104, "R6 low half only", cfg_rdata, 32'h0005_0104);
    step(20);

    tag = "R5";
    wr_cfg(2'b10, 32'hF3FF_0000);
    chk(cfg_rdata === 32'h03FF_0104, "R5 reserved bits dropped", cfg_rdata, 32'h03FF_0104);

    tag = "R7";
    wr_cfg(2'b01, 32'h0000_0300);
    step(2);
    clear_counts();
    step(100);
    chk(n_div[0] == 0, "R7 divide 0 quiet", n_div[0], 0);

    tag = "R8";
    wr_cfg(2'b01, 32'h0000_0C01);
    step(2);
    clear_counts();
    step(100);
    chk(n_div[0] == 0, "R8 mux 12 quiet", n_div[0], 0);

    tag = "R3";
    wr_src(4'b0001, 4'd13);
    chk(src_sel[3:0] === 4'd11, "R3 code 13 ignored", 32'(src_sel[3:0]), 32'd11);
    wr_src(4'b1111, 4'd15);
    chk(src_sel === 16'hCC1B, "R3 code 15 ignored", 32'(src_sel), 32'h0000_CC1B);
    step(10);

    tag = "R9";
    rst = 1'b1;
    step(2);
    chk(cfg_rdata === 32'h0 && src_sel === '0 && ch_tick === '0, "R9 second reset", cfg_rdata, 32'h0);
    rst = 1'b0;
    step(5);
    finish_run();
  end

endmodule